// File: doc/BRIEF.md
# Interrupt Flag and Enable Registers

This block collects the interrupt sources of a small parallel-port and timer peripheral into one request line. It keeps a seven-bit pending-event register and a seven-bit mask register. A byte-wide CPU port reaches both registers at fixed offsets. Sources raise single-cycle set strobes for their flag bits. Neighbouring sub-blocks report clear-on-read side effects through clear strobes. A read of the shift-data offset also clears the shift event flag here.

The pending register is write-one-to-clear. Its read value carries a computed summary in the top bit, which is one whenever some pending bit is also unmasked. The mask register is written in a set-or-clear mode that bit 7 of the written byte selects. It always reads back with bit 7 high. The interrupt line is the OR of the pending bits that are unmasked.

Top module: `intr_flag_enable`

## Requirements
- R1: After a synchronous active-low reset, all pending bits and mask bits are zero, `irq` is low and `rdata` is 0x00.
- R2: A selected write to offset 13 clears each pending bit whose bit in `wdata[6:0]` is one. Pending bits written with zero keep their value, and `wdata[7]` is ignored.
- R3: A selected read of offset 13 returns the pending bits in bits 6:0. Bit 7 is one exactly when the pending and mask registers share a set bit.
- R4: A selected write to offset 14 with `wdata[7]`=1 sets the mask bits that are one in `wdata[6:0]`. With `wdata[7]`=0 it clears those mask bits instead. All other mask bits keep their value.
- R5: A selected read of offset 14 returns the mask bits in bits 6:0 with bit 7 always one.
- R6: A selected read of offset 10 clears pending bit 2, the shift event flag, and no other pending bit.
- R7: `irq` is high exactly when the pending AND mask registers are non-zero. It reflects a register change in the cycle after the clock edge that makes the change.
- R8: A one on `set_strb[i]` sets pending bit i at the next edge. If a clear arrives for the same bit in the same cycle, by any path, the bit still ends up set.
- R9: A one on `clr_strb[i]` with no set for that bit clears pending bit i at the next edge.
- R10: Read data is registered and appears on `rdata` after the edge that samples the read. A selected read of any offset other than 13 or 14 returns 0x00.
- R11: An access with `sel` low, or a write to an offset other than 13 or 14, changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | CPU port select |
| rd | input | 1 | Read request, qualified by sel |
| wr | input | 1 | Write request, qualified by sel |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| set_strb | input | 7 | Per-bit pending set strobes from sources |
| clr_strb | input | 7 | Per-bit pending clear strobes from neighbouring sub-blocks |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a set strobe into a bit in the same cycle as a write-one-to-clear, a shift-offset read or a clear strobe for that bit. A design that let the clear win would drop the event and leave `irq` low. It writes the mask register with both values of bit 7, so a design that ignored the mode would set bits when it should clear them. It reads the flag register with pending bits that are all masked and then with one bit unmasked. This separates a summary bit built from the raw flags from one built from the masked flags. Reads through the shift offset and through unmapped offsets, and accesses with `sel` low, expose a decoder that clears the wrong flags or leaks register contents.

// File: rtl/intr_pkg.sv
// Package: shared constants and helpers for the interrupt flag/enable block.
// Assumes an 8-bit CPU data path with one summary bit above the sources.
package intr_pkg;

    // Default number of interrupt sources (one flag bit each)
    localparam int unsigned DEF_NSRC = 7;

    // Default register offsets on the CPU port
    localparam int unsigned DEF_FLAG_OFS  = 13;
    localparam int unsigned DEF_MASK_OFS  = 14;
    localparam int unsigned DEF_SHIFT_OFS = 10;

    // Decoded access strobes shared between decoder and datapath
    typedef struct packed {
        logic flag_wr;
        logic flag_rd;
        logic mask_wr;
        logic mask_rd;
        logic shift_rd;
        logic any_rd;
    } access_t;

endpackage

// File: rtl/intr_decode.sv
// Module: intr_decode
// Turns the raw select/read/write/offset inputs into one-hot access strobes.
// Assumes the offset parameters are distinct and fit the address width.
module intr_decode #(
    parameter int unsigned AW        = 4,
    parameter int unsigned FLAG_OFS  = 13,
    parameter int unsigned MASK_OFS  = 14,
    parameter int unsigned SHIFT_OFS = 10
) (
    input  logic               sel,
    input  logic               rd,
    input  logic               wr,
    input  logic [AW-1:0]      addr,
    output intr_pkg::access_t  acc
);
    localparam logic [AW-1:0] A_FLAG  = AW'(FLAG_OFS);
    localparam logic [AW-1:0] A_MASK  = AW'(MASK_OFS);
    localparam logic [AW-1:0] A_SHIFT = AW'(SHIFT_OFS);

    // Offset compare qualified by select and direction
    always_comb begin
        acc.any_rd   = sel && rd;
        acc.flag_rd  = sel && rd && (addr == A_FLAG);
        acc.mask_rd  = sel && rd && (addr == A_MASK);
        acc.shift_rd = sel && rd && (addr == A_SHIFT);
        acc.flag_wr  = sel && wr && (addr == A_FLAG);
        acc.mask_wr  = sel && wr && (addr == A_MASK);
    end

    // Strobes only fire when select is high
    always_comb begin
        if (!sel) begin
            AST_DEC_IDLE: assert (!(acc.any_rd || acc.flag_wr || acc.mask_wr)); // R11
        end
    end
endmodule

// File: rtl/intr_flag_bank.sv
// Module: intr_flag_bank
// Pending-event flags, one flop per source. A set strobe always wins over any
// clear request for the same bit, so no event is lost.
// Assumes set_i and clr_i are single-cycle masks sampled at each edge.
module intr_flag_bank #(
    parameter int unsigned NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);
    // One flag cell per source with set priority
    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R8

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0)); // R9

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(flag_o)); // R2
endmodule

// File: rtl/intr_mask_bank.sv
// Module: intr_mask_bank
// Interrupt mask register written in set-or-clear mode chosen by the top data
// bit. Assumes wdata is NSRC+1 bits with the mode bit on top.
module intr_mask_bank #(
    parameter int unsigned NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [NSRC:0]   wdata_i,
    output logic [NSRC-1:0] mask_o
);
    logic             mode_set;
    logic [NSRC-1:0]  bits;

    // Split the written byte into mode and bit selection
    always_comb begin
        mode_set = wdata_i[NSRC];
        bits     = wdata_i[NSRC-1:0];
    end

    // Apply set or clear of the selected mask bits
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_o <= '0;
        else if (wr_i) begin
            if (mode_set)  mask_o <= mask_o | bits;
            else           mask_o <= mask_o & ~bits;
        end
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[NSRC]) |=> ((mask_o & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0]))); // R4

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wdata_i[NSRC]) |=> ((mask_o & $past(wdata_i[NSRC-1:0])) == '0)); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o)); // R11
endmodule

// File: rtl/intr_read_port.sv
// Module: intr_read_port
// Registered read data for the two register offsets; others read zero.
// Assumes at most one of flag_rd / mask_rd is high in a cycle.
module intr_read_port #(
    parameter int unsigned NSRC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  intr_pkg::access_t acc,
    input  logic [NSRC-1:0]   flag_i,
    input  logic [NSRC-1:0]   mask_i,
    output logic [NSRC:0]     rdata_o
);
    logic [NSRC:0] mux;

    // Select the read value for the addressed register
    always_comb begin
        if (acc.flag_rd)      mux = {|(flag_i & mask_i), flag_i};
        else if (acc.mask_rd) mux = {1'b1, mask_i};
        else                  mux = '0;
    end

    // Capture on any selected read
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_o <= '0;
        else if (acc.any_rd) rdata_o <= mux;
    end

    AST_MASK_RD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        acc.mask_rd |=> rdata_o[NSRC]); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.any_rd |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/intr_flag_enable.sv
// Module: intr_flag_enable (top)
// Interrupt aggregation: pending flags, mask, CPU byte port and request line.
// Assumes clear strobes from neighbours are already qualified single pulses.
module intr_flag_enable #(
    parameter int unsigned NSRC       = intr_pkg::DEF_NSRC,
    parameter int unsigned AW         = 4,
    parameter int unsigned FLAG_OFS   = intr_pkg::DEF_FLAG_OFS,
    parameter int unsigned MASK_OFS   = intr_pkg::DEF_MASK_OFS,
    parameter int unsigned SHIFT_OFS  = intr_pkg::DEF_SHIFT_OFS,
    parameter int unsigned SHIFT_BIT  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            rd,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [NSRC:0]   wdata,
    output logic [NSRC:0]   rdata,
    input  logic [NSRC-1:0] set_strb,
    input  logic [NSRC-1:0] clr_strb,
    output logic            irq
);
    localparam logic [NSRC-1:0] SHIFT_MASK = NSRC'(1) << SHIFT_BIT;

    intr_pkg::access_t acc;
    logic [NSRC-1:0]   flags;
    logic [NSRC-1:0]   mask;
    logic [NSRC-1:0]   clr_all;

    intr_decode #(
        .AW(AW), .FLAG_OFS(FLAG_OFS), .MASK_OFS(MASK_OFS), .SHIFT_OFS(SHIFT_OFS)
    ) u_decode (
        .sel(sel), .rd(rd), .wr(wr), .addr(addr), .acc(acc)
    );

    // Merge every clear path into one mask for the flag bank
    always_comb begin
        clr_all = clr_strb;
        if (acc.flag_wr)  clr_all = clr_all | wdata[NSRC-1:0];
        if (acc.shift_rd) clr_all = clr_all | SHIFT_MASK;
    end

    intr_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_strb), .clr_i(clr_all), .flag_o(flags)
    );

    intr_mask_bank #(.NSRC(NSRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(acc.mask_wr), .wdata_i(wdata), .mask_o(mask)
    );

    intr_read_port #(.NSRC(NSRC)) u_read (
        .clk(clk), .rst_n(rst_n), .acc(acc), .flag_i(flags), .mask_i(mask), .rdata_o(rdata)
    );

    // Request line from unmasked pending flags
    always_comb irq = |(flags & mask);

    AST_SHIFT_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.shift_rd && !set_strb[SHIFT_BIT]) |=> !flags[SHIFT_BIT]); // R6

    AST_FLAG_RD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        acc.flag_rd |=> (rdata[NSRC] == $past(irq))); // R3

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R7
endmodule

// File: tb/intr_flag_enable_tb.sv
`timescale 1ns/1ps
module intr_flag_enable_tb;
    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sel, rd, wr;
    logic [3:0]   addr;
    logic [7:0]   wdata;
    logic [7:0]   rdata;
    logic [N-1:0] set_strb, clr_strb;
    logic         irq;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] m_flag, m_mask;
    logic [7:0]   m_rdata;

    always #4 clk = ~clk;

    intr_flag_enable u_dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .set_strb(set_strb), .clr_strb(clr_strb), .irq(irq)
    );

    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [N-1:0] f,
                                            input logic [N-1:0] m);
        if (a == 4'd13)      return {|(f & m), f};
        else if (a == 4'd14) return {1'b1, m};
        else                 return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, model the edge, check at the next negedge
    task automatic cyc(input string req, input logic s, input logic r, input logic w,
                       input logic [3:0] a, input logic [7:0] d,
                       input logic [N-1:0] st, input logic [N-1:0] cl);
        logic [N-1:0] clr;
        sel = s; rd = r; wr = w; addr = a; wdata = d; set_strb = st; clr_strb = cl;
        clr = cl;
        if (s && w && a == 4'd13) clr |= d[N-1:0];
        if (s && r && a == 4'd10) clr |= 7'b0000100;
        if (s && r) m_rdata = exp_read(a, m_flag, m_mask);
        @(posedge clk);
        m_flag = (m_flag & ~clr) | st;
        if (s && w && a == 4'd14) m_mask = d[7] ? (m_mask | d[N-1:0]) : (m_mask & ~d[N-1:0]);
        @(negedge clk);
        check({req, " irq"}, {7'd0, irq}, {7'd0, |(m_flag & m_mask)});
        check({req, " rdata"}, rdata, m_rdata);
    endtask

    task automatic idle(); cyc("idle", 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 0; sel = 0; rd = 0; wr = 0; addr = 0; wdata = 0; set_strb = 0; clr_strb = 0;
        m_flag = 0; m_mask = 0; m_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        rst_n = 1;
        cyc("R1 flag read", 1, 1, 0, 13, 0, 0, 0);
        cyc("R1 mask read", 1, 1, 0, 14, 0, 0, 0);

        // R8 sets, R3 summary with all masked
        cyc("R8 set", 0, 0, 0, 0, 0, 7'h65, 0);
        cyc("R3 masked read", 1, 1, 0, 13, 0, 0, 0);
        // R4 set mode then clear mode
        cyc("R4 set mode", 1, 0, 1, 14, 8'h82, 0, 0);
        cyc("R4 set mode2", 1, 0, 1, 14, 8'hC0, 0, 0);
        cyc("R5 mask read", 1, 1, 0, 14, 0, 0, 0);
        cyc("R3 summary read", 1, 1, 0, 13, 0, 0, 0);
        cyc("R4 clear mode", 1, 0, 1, 14, 8'h40, 0, 0);
        cyc("R7 irq after clear", 1, 1, 0, 14, 0, 0, 0);
        // R2 write one to clear, zeros keep
        cyc("R2 w1c", 1, 0, 1, 13, 8'h81, 0, 0);
        cyc("R2 read", 1, 1, 0, 13, 0, 0, 0);
        // R6 shift read clears bit 2 only
        cyc("R6 shift read", 1, 1, 0, 10, 0, 0, 0);
        cyc("R6 check", 1, 1, 0, 13, 0, 0, 0);
        // R8 collisions: set wins over each clear path
        cyc("R8 vs w1c", 1, 0, 1, 13, 8'h7F, 7'h10, 0);
        cyc("R8 vs shift", 1, 1, 0, 10, 0, 7'h04, 0);
        cyc("R8 vs strb", 0, 0, 0, 0, 0, 7'h02, 7'h02);
        cyc("R8 read", 1, 1, 0, 13, 0, 0, 0);
        // R9 clear strobe
        cyc("R9 clr strobe", 0, 0, 0, 0, 0, 0, 7'h14);
        cyc("R9 read", 1, 1, 0, 13, 0, 0, 0);
        // R10 unmapped read, R11 no-select and stray writes
        cyc("R10 unmapped", 1, 1, 0, 3, 0, 0, 0);
        cyc("R11 nosel", 0, 1, 1, 13, 8'hFF, 0, 0);
        cyc("R11 stray wr", 1, 0, 1, 5, 8'hFF, 0, 0);
        cyc("R11 read", 1, 1, 0, 14, 0, 0, 0);
        idle();

        // R7 random mix
        for (int i = 0; i < 600; i++) begin
            int op = $urandom % 6;
            logic [N-1:0] st = ($urandom % 3 == 0) ? N'(1 << ($urandom % N)) : '0;
            logic [N-1:0] cl = ($urandom % 4 == 0) ? N'($urandom) : '0;
            logic [3:0]   a  = ($urandom % 2) ? 4'(13 + $urandom % 2) : 4'($urandom);
            logic [7:0]   d  = 8'($urandom);
            case (op)
                0, 1: cyc("R7 rand rd", 1, 1, 0, a, 0, st, cl);
                2, 3: cyc("R7 rand wr", 1, 0, 1, a, d, st, cl);
                4:    cyc("R7 rand shift", 1, 1, 0, 10, 0, st, cl);
                default: cyc("R7 rand idle", 0, $urandom % 2 == 0, $urandom % 2 == 0, a, d, st, cl);
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule